// File: doc/BRIEF.md
# Serial link frame encoder

This block is the transmit framing core of a point-to-point serial link. Once per frame it samples a parallel word and two active-low request strobes. The strobes decide whether the frame carries a control word, a data word, or an idle fill pattern. The block prefixes the payload with a 4-bit code that marks the frame type. It then shifts the frame out one bit per bit-rate enable, least significant bit first. A mode input sets the payload to 16 or 20 bits, so a frame is 20 or 24 bits long.

An idle link sends fill frames in a fixed alternating pair, which keeps the line DC balanced. A double-frame mode sends a 32- or 40-bit word as two consecutive frames, lower half first. A pulse marks each cycle in which the block takes a new input word, and the user's word rate follows that pulse. The multiplied serial clock is outside this block. A bit-rate enable stands in for it.

Top module: `link_frame_tx`

## Requirements
- R1: A frame is 20 bits when `wide_sel` is 0 and 24 bits when it is 1, sent LSB first. Bits 0..3 hold the type code and bits 4 upward hold the payload (16 or 20 bits).
- R2: When `ctl_req_n` is 0 the frame is a control frame, whatever `dat_req_n` is. Its code is 4'b0011. Its payload is bits 17..0 of the selected half word (the two 9-bit groups 8..0 and 17..9), zero-extended and cut to the payload width.
- R3: When `ctl_req_n` is 1 and `dat_req_n` is 0 the frame is a data frame. Its code is 4'b1101 and its payload is the selected half word cut to the payload width.
- R4: When both strobes are 1 a fill frame is sent. Fill frames alternate between two forms: code 4'b0100 with the pattern FILL_PAT (default 20'h3C5A9), and code 4'b1011 with the bitwise complement of FILL_PAT. Both forms are cut to the payload width. The alternation advances on every fill frame.
- R5: Two consecutive fill frames of the same width together carry exactly as many ones as one frame has bits.
- R6: When `dbl_mode` is 1 at the frame where a word is taken, the word is sent as two frames: bits W-1..0 first and bits 2W-1..W second, where W is the payload width. The strobes and the width are sampled once and apply to both halves, and no word is taken at the second half.
- R7: `bit_stb` is high for one cycle, one clock after each cycle in which `bit_en` is high, and `ser_out` is valid while it is high. A new frame's bit 0 follows the last bit of the previous frame at the next enable. `frame_start` is high only together with bit 0.
- R8: A change of `wide_sel` during a frame has no effect until the next frame boundary.
- R9: While `rst_n` is 0 (synchronous), `ser_out`, `bit_stb`, `frame_start` and `word_take` are 0. The first frame after reset is the first fill form (code 4'b0100) and takes no word.
- R10: `word_take` is high together with `frame_start` on every frame that samples the input word and strobes, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per high cycle |
| wide_sel | input | 1 | Payload width: 0 gives 16 bits, 1 gives 20 bits |
| dbl_mode | input | 1 | Send the wide input word as two frames |
| ctl_req_n | input | 1 | Active-low control word request |
| dat_req_n | input | 1 | Active-low data word request |
| word_in | input | 40 | Parallel input word (both halves) |
| ser_out | output | 1 | Serial data bit |
| bit_stb | output | 1 | Marks a valid serial bit |
| frame_start | output | 1 | High with bit 0 of each frame |
| word_take | output | 1 | The input word and strobes were sampled for this frame |

## Verification
Two events can fall in one cycle: a change of the width input or of the strobes, and the load of the next frame. The same is true of the second half of a double frame and a fresh request that arrives while it is pending. The bench changes the width, the mode, the strobes and the word at random negative edges with an irregular bit enable, so these changes land both inside frames and right on the boundary. Each frame is judged against a model that snapshots the inputs only at the load edge. Any leak of a mid-frame change, or any request that overrides a pending second half, shows up as a mismatch in frame length, code or payload.

// File: rtl/link_frame_tx.sv
module link_frame_tx #(
  parameter int PW       = 20,
  parameter int NARROW   = 16,
  parameter int CTRL_W   = 18,
  parameter logic [PW-1:0] FILL_PAT = 20'h3C5A9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          wide_sel,
  input  logic          dbl_mode,
  input  logic          ctl_req_n,
  input  logic          dat_req_n,
  input  logic [2*PW-1:0] word_in,
  output logic          ser_out,
  output logic          bit_stb,
  output logic          frame_start,
  output logic          word_take
);
  localparam int FW   = PW + 4;
  localparam int CNTW = $clog2(FW);
  localparam logic [CNTW-1:0] LAST_W = CNTW'(FW - 1);
  localparam logic [CNTW-1:0] LAST_N = CNTW'(NARROW + 3);
  localparam logic [PW-1:0] MASK_N = {{(PW-NARROW){1'b0}}, {NARROW{1'b1}}};
  localparam logic [PW-1:0] MASK_C = {{(PW-CTRL_W){1'b0}}, {CTRL_W{1'b1}}};

  typedef enum logic [1:0] {K_FILL, K_DAT, K_CTL} kind_t;

  logic [FW-1:0]   sh;
  logic [CNTW-1:0] cnt;
  logic            running, cur_wide, fill_ph;
  kind_t           cur_kind;
  logic            h2_pend, h2_wide;
  kind_t           h2_kind;
  logic [PW-1:0]   h2_word;

  logic            load, take, new_wide;
  kind_t           kind_in, kind;
  logic [PW-1:0]   wmask, lo, hi, half, payload;
  logic [3:0]      code;

  assign load     = !running || cnt == (cur_wide ? LAST_W : LAST_N);
  assign take     = running && !h2_pend;
  assign new_wide = h2_pend ? h2_wide : wide_sel;
  assign kind_in  = !ctl_req_n ? K_CTL : (!dat_req_n ? K_DAT : K_FILL);
  assign kind     = !running ? K_FILL : (h2_pend ? h2_kind : kind_in);
  assign wmask    = new_wide ? {PW{1'b1}} : MASK_N;
  assign lo       = word_in[PW-1:0] & wmask;
  assign hi       = new_wide ? word_in[2*PW-1:PW]
                             : {{(PW-NARROW){1'b0}}, word_in[2*NARROW-1:NARROW]};
  assign half     = h2_pend ? h2_word : lo;

  always_comb begin
    case (kind)
      K_CTL:   begin payload = half & MASK_C & wmask; code = 4'b0011; end
      K_DAT:   begin payload = half & wmask;          code = 4'b1101; end
      default: begin
        payload = (fill_ph ? ~FILL_PAT : FILL_PAT) & wmask;
        code    = fill_ph ? 4'b1011 : 4'b0100;
      end
    endcase
  end

  assign ser_out = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh          <= '0;
      cnt         <= '0;
      running     <= 1'b0;
      cur_wide    <= 1'b0;
      cur_kind    <= K_FILL;
      fill_ph     <= 1'b0;
      h2_pend     <= 1'b0;
      h2_wide     <= 1'b0;
      h2_kind     <= K_FILL;
      h2_word     <= '0;
      bit_stb     <= 1'b0;
      frame_start <= 1'b0;
      word_take   <= 1'b0;
    end else begin
      bit_stb     <= bit_en;
      frame_start <= 1'b0;
      word_take   <= 1'b0;
      if (bit_en) begin
        if (load) begin
          sh          <= {payload, code};
          cnt         <= '0;
          running     <= 1'b1;
          cur_wide    <= new_wide;
          cur_kind    <= kind;
          frame_start <= 1'b1;
          word_take   <= take;
          if (kind == K_FILL) fill_ph <= ~fill_ph;
          if (take && dbl_mode) begin
            h2_pend <= 1'b1;
            h2_kind <= kind;
            h2_wide <= new_wide;
            h2_word <= hi & wmask;
          end else begin
            h2_pend <= 1'b0;
          end
        end else begin
          sh  <= sh >> 1;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_stb_follows_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> bit_stb);
  assert_start_with_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> bit_stb);
  assert_take_in_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> frame_start);
  assert_fill_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cur_kind == K_FILL) |-> (sh[3:0] == 4'b0100 || sh[3:0] == 4'b1011));
  assert_half2_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && load && h2_pend) |=> (frame_start && !word_take));
endmodule

// File: tb/tb_link_frame_tx.sv
module tb_link_frame_tx;
  localparam logic [19:0] PAT = 20'h3C5A9;

  logic clk = 0, rst_n = 0, bit_en = 0, wide_sel = 0, dbl_mode = 0;
  logic ctl_req_n = 1, dat_req_n = 1;
  logic [39:0] word_in = '0;
  logic ser_out, bit_stb, frame_start, word_take;

  link_frame_tx dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wide_sel(wide_sel),
    .dbl_mode(dbl_mode), .ctl_req_n(ctl_req_n), .dat_req_n(dat_req_n), .word_in(word_in),
    .ser_out(ser_out), .bit_stb(bit_stb), .frame_start(frame_start), .word_take(word_take));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0, done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [1:0] k, input logic w, input logic [19:0] hf, input logic ph);
    logic [19:0] m, p;
    logic [3:0] c;
    m = w ? 20'hFFFFF : 20'h0FFFF;
    case (k)
      2'd2:    begin p = hf & 20'h3FFFF & m; c = 4'b0011; end
      2'd1:    begin p = hf & m; c = 4'b1101; end
      default: begin p = (ph ? ~PAT : PAT) & m; c = ph ? 4'b1011 : 4'b0100; end
    endcase
    return {p, c};
  endfunction

  // model state
  bit first = 1, h2 = 0, h2w = 0, ph = 0, coll = 0, prev_fillA = 0, prev_w = 0;
  logic [1:0] h2k, ek;
  logic [19:0] h2word;
  logic [23:0] exp_f, got, prev_f;
  int elen, cnt, idle_cyc;
  string tag;
  bit wchg = 0, cur_fill, cur_ph, cur_w;

  always @(negedge clk) begin
    if (mon_on && !done) begin
      idle_cyc++;
      if (idle_cyc > 2000) begin
        check(0, "R7 watchdog", idle_cyc, 0);
        idle_cyc = 0;
      end
      if (word_take && !frame_start) check(0, "R10 take without start", 1, 0);
      if (frame_start && !bit_stb) check(0, "R7 start without bit", 0, 1);
      if (bit_stb) begin
        if (frame_start) begin
          logic take_e;
          logic [19:0] hf, mm;
          idle_cyc = 0;
          if (coll) check(cnt == elen, "R1 frame length", cnt, elen);
          mm = wide_sel ? 20'hFFFFF : 20'h0FFFF;
          if (first) begin
            ek = 0; cur_w = wide_sel; hf = '0; take_e = 0; tag = "R9"; first = 0;
          end else if (h2) begin
            ek = h2k; cur_w = h2w; hf = h2word; take_e = 0; h2 = 0; tag = "R6";
          end else begin
            ek = !ctl_req_n ? 2'd2 : (!dat_req_n ? 2'd1 : 2'd0);
            cur_w = wide_sel; hf = word_in[19:0] & mm; take_e = 1;
            tag = (ek == 2) ? "R2" : (ek == 1) ? "R3" : "R4";
            if (dbl_mode) begin
              h2 = 1; h2k = ek; h2w = wide_sel; tag = "R6";
              h2word = (wide_sel ? word_in[39:20] : {4'h0, word_in[31:16]}) & mm;
            end
          end
          if (wchg && tag != "R6") tag = "R8";
          wchg = 0;
          check(word_take == take_e, "R10 word_take", word_take, take_e);
          cur_fill = (ek == 0); cur_ph = ph;
          exp_f = mk(ek, cur_w, hf, ph);
          if (ek == 0) ph = ~ph;
          elen = cur_w ? 24 : 20;
          cnt = 0; got = '0; coll = 1;
        end
        if (coll && cnt < 24) begin
          got[cnt] = ser_out;
          cnt++;
          if (cnt == elen) begin
            check(got == exp_f, tag, got, exp_f);
            if (cur_fill && cur_ph && prev_fillA && prev_w == cur_w)
              check($countones(got) + $countones(prev_f) == elen, "R5 fill balance",
                    $countones(got) + $countones(prev_f), elen);
            prev_fillA = cur_fill && !cur_ph;
            prev_w = cur_w;
            prev_f = got;
          end
        end
      end
    end
  end

  task automatic step(input int n, input int en_pct, input int wchg_pct, input int dbl_pct, input int kmode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      bit_en = ($urandom % 100) < en_pct;
      if (($urandom % 100) < wchg_pct) begin wide_sel = ~wide_sel; if (coll) wchg = 1; end
      if (($urandom % 100) < dbl_pct) dbl_mode = ~dbl_mode;
      if (kmode == 0) begin ctl_req_n = 1; dat_req_n = 1; end
      else if (($urandom % 8) == 0) begin
        ctl_req_n = $urandom % 3 == 0; ctl_req_n = ~ctl_req_n | (kmode == 1);
        dat_req_n = $urandom % 4 == 0;
        if (kmode == 3) begin ctl_req_n = 0; dat_req_n = 0; end
      end
      if (($urandom % 4) == 0) word_in = {$urandom, $urandom};
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    check(ser_out == 0 && bit_stb == 0 && frame_start == 0 && word_take == 0, "R9 reset outputs",
          {ser_out, bit_stb, frame_start, word_take}, 0);
    bit_en = 1;
    @(negedge clk);
    check(bit_stb == 0 && frame_start == 0, "R9 outputs held in reset", {bit_stb, frame_start}, 0);
    #1 rst_n = 1; mon_on = 1;
    step(300, 100, 0, 0, 0);   // idle narrow, continuous enable
    #1 wide_sel = 1;
    step(300, 60, 0, 0, 0);    // idle wide
    step(400, 100, 0, 0, 3);   // both strobes low: control priority
    step(400, 100, 0, 0, 1);   // data only
    step(6000, 70, 2, 0, 2);   // mixed, mid-frame width changes
    #1 dbl_mode = 1;
    step(6000, 80, 2, 0, 2);   // double mode
    step(6000, 75, 3, 2, 2);   // everything changing
    step(60, 0, 0, 0, 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule